// File: doc/BRIEF.md
# Temperature Limit Window Alert

This block watches a stream of temperature samples and raises an alert when a sample leaves a programmable window. Samples and both limits are 12-bit signed two's-complement numbers, 16 LSB per degree Celsius. Each sample arrives with a one-cycle valid strobe. The block compares the sample against the high and low limits in that cycle and updates two sticky flags, an alert output and a direction bit on the next clock edge.

There are two alert behaviours. In comparator mode the alert follows the flags, and each flag falls back only once a sample has moved past its limit by a selectable hysteresis margin. In interrupt mode an out-of-window sample latches the alert. The latch holds until a configuration-read pulse or an alert-response-win pulse arrives. The read pulse also clears the flags, while the win pulse clears only the alert. A reset-command pulse returns all state to its reset values. The surrounding register file supplies the limits, the mode, the hysteresis code and the polarity. It also reports the bus events as single-cycle pulses.

Top module: `thermal_limit_alert`

## Requirements
- R1: While reset is held, and after it is released, both flags and the direction bit are 0 and the alert is inactive. The alert pin is at 1 with polarity 0.
- R2: A valid sample sets the high flag when it is strictly greater than the high limit, and sets the low flag when it is strictly less than the low limit. Both comparisons are signed. A sample equal to a limit sets nothing, so with the limits at 0x7FF and 0x800 no 12-bit sample can set a flag.
- R3: Hysteresis code 0, 1, 2 and 3 selects a margin of 0, 16, 32 and 64 LSB (0, 1, 2 and 4 °C).
- R4: In comparator mode (mode input 0) the alert is active exactly while either flag is set. The high flag clears on a valid sample strictly below high limit minus margin. The low flag clears on a valid sample strictly above low limit plus margin. Samples between a limit and its release point leave the flag unchanged.
- R5: In interrupt mode (mode input 1) an out-of-window sample latches the alert and the matching flag. Later in-window samples leave both unchanged.
- R6: In interrupt mode a configuration-read pulse clears both flags and the alert. In comparator mode the pulse has no effect on the flags or the alert.
- R7: In interrupt mode an alert-response-win pulse clears the alert and leaves both flags unchanged.
- R8: When an out-of-window sample coincides with a read or win pulse in interrupt mode, the alert and the matching flag end up set.
- R9: With polarity 0 the pin is low while the alert is active and high otherwise. With polarity 1 the pin equals the alert state. A polarity change takes effect without waiting for a clock edge.
- R10: On every out-of-window sample the direction bit loads 1 if the sample was over the high limit and 0 if it was only under the low limit. Otherwise the direction bit holds.
- R11: A reset-command pulse clears both flags, the alert and the direction bit, even if a valid sample arrives in the same cycle.
- R12: Flags, alert and direction bit change only on the edge after a valid sample or a clear pulse, and are stable otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | One-cycle strobe marking a new sample |
| sampleData | input | 12 | Signed temperature sample, 16 LSB per °C |
| limitHigh | input | 12 | Signed upper limit |
| limitLow | input | 12 | Signed lower limit |
| intMode | input | 1 | 1 selects latched interrupt mode, 0 selects comparator mode |
| hystCode | input | 2 | Hysteresis select: 0, 1, 2 or 4 °C |
| alertPolarity | input | 1 | 0 drives the alert active low, 1 active high |
| cfgReadClr | input | 1 | Pulse from a configuration-register read |
| arwinClr | input | 1 | Pulse from a won alert response |
| resetCmd | input | 1 | Pulse from a reset command |
| flagHigh | output | 1 | Over-limit flag |
| flagLow | output | 1 | Under-limit flag |
| alertPin | output | 1 | Alert level after polarity |
| arDirBit | output | 1 | Cause of the last event: 1 over high, 0 under low |

## Verification
The properties assume that the strobes and pulses last a single cycle. They also assume that the mode input changes only between samples; each property that spans a cycle allows for a mode change in the following cycle. The bench drives every input on the falling clock edge and changes the limits, mode, hysteresis and polarity only while no sample is in flight. It sweeps all 4096 sample codes against the reset-value limits and against a narrow window. It also walks samples up and down through both limits under each hysteresis code, so that every release point is crossed from both sides.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;

  // Comparison results handed from the datapath to the control
  typedef struct packed {
    logic overHigh;     // sample > high limit
    logic underLow;     // sample < low limit
    logic highRelease;  // sample < high limit - margin
    logic lowRelease;   // sample > low limit + margin
  } cmp_t;

  // Update strobes handed from the control to the datapath registers
  typedef struct packed {
    logic setHigh;
    logic clrHigh;
    logic setLow;
    logic clrLow;
    logic setAlert;
    logic clrAlert;
    logic loadDir;
    logic dirVal;
    logic wipe;
  } strobe_t;

endpackage

// File: rtl/thermal_alert_datapath.sv
module thermal_alert_datapath
  import thermal_alert_pkg::*;
#(
  parameter int TEMP_W    = 12,
  parameter int FRAC_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] sampleData,
  input  logic [TEMP_W-1:0] limitHigh,
  input  logic [TEMP_W-1:0] limitLow,
  input  logic [1:0]        hystCode,
  input  strobe_t           stb,
  output cmp_t              cmp,
  output logic              flagHigh,
  output logic              flagLow,
  output logic              alertLatch,
  output logic              dirBit
);

  // Two guard bits keep limit +/- margin free of wrap-around
  localparam int EXT_W     = TEMP_W + 2;
  localparam int HYST_CNT  = 4;

  logic [EXT_W-1:0] hystTable [HYST_CNT];

  // Margin per code: 0, 1, 2, 4 degrees, scaled to LSBs
  for (genvar g = 0; g < HYST_CNT; g++) begin : gHyst
    localparam int DEG = (g == HYST_CNT - 1) ? 4 : g;
    assign hystTable[g] = EXT_W'(DEG << FRAC_BITS);
  end

  logic signed [EXT_W-1:0] sampleExt;
  logic signed [EXT_W-1:0] highExt;
  logic signed [EXT_W-1:0] lowExt;
  logic signed [EXT_W-1:0] marginExt;
  logic signed [EXT_W-1:0] highRelPoint;
  logic signed [EXT_W-1:0] lowRelPoint;

  always_comb begin
    sampleExt    = $signed({{2{sampleData[TEMP_W-1]}}, sampleData});
    highExt      = $signed({{2{limitHigh[TEMP_W-1]}}, limitHigh});
    lowExt       = $signed({{2{limitLow[TEMP_W-1]}}, limitLow});
    marginExt    = $signed(hystTable[hystCode]);
    highRelPoint = highExt - marginExt;
    lowRelPoint  = lowExt + marginExt;

    cmp.overHigh    = sampleExt > highExt;
    cmp.underLow    = sampleExt < lowExt;
    cmp.highRelease = sampleExt < highRelPoint;
    cmp.lowRelease  = sampleExt > lowRelPoint;
  end

  // Set dominates clear; wipe dominates both
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagHigh   <= 1'b0;
      flagLow    <= 1'b0;
      alertLatch <= 1'b0;
      dirBit     <= 1'b0;
    end else if (stb.wipe) begin
      flagHigh   <= 1'b0;
      flagLow    <= 1'b0;
      alertLatch <= 1'b0;
      dirBit     <= 1'b0;
    end else begin
      if (stb.setHigh)       flagHigh <= 1'b1;
      else if (stb.clrHigh)  flagHigh <= 1'b0;

      if (stb.setLow)        flagLow <= 1'b1;
      else if (stb.clrLow)   flagLow <= 1'b0;

      if (stb.setAlert)      alertLatch <= 1'b1;
      else if (stb.clrAlert) alertLatch <= 1'b0;

      if (stb.loadDir)       dirBit <= stb.dirVal;
    end
  end

endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
  import thermal_alert_pkg::*;
(
  input  logic    sampleValid,
  input  logic    intMode,
  input  logic    cfgReadClr,
  input  logic    arwinClr,
  input  logic    resetCmd,
  input  cmp_t    cmp,
  output strobe_t stb
);

  logic hitHigh;
  logic hitLow;
  logic anyHit;

  always_comb begin
    hitHigh = sampleValid & cmp.overHigh;
    hitLow  = sampleValid & cmp.underLow;
    anyHit  = hitHigh | hitLow;

    stb = '0;
    if (resetCmd) begin
      stb.wipe = 1'b1;
    end else begin
      stb.setHigh = hitHigh;
      stb.setLow  = hitLow;
      stb.loadDir = anyHit;
      stb.dirVal  = hitHigh;
      if (intMode) begin
        // Latched behaviour: the read clears flags and pin, the win only the pin
        stb.clrHigh  = cfgReadClr;
        stb.clrLow   = cfgReadClr;
        stb.setAlert = anyHit;
        stb.clrAlert = cfgReadClr | arwinClr;
      end else begin
        // Comparator behaviour: flags fall back past the hysteresis point
        stb.clrHigh  = sampleValid & cmp.highRelease;
        stb.clrLow   = sampleValid & cmp.lowRelease;
        stb.clrAlert = 1'b1;
      end
    end
  end

endmodule

// File: rtl/thermal_limit_alert.sv
module thermal_limit_alert
  import thermal_alert_pkg::*;
#(
  parameter int TEMP_W    = 12,
  parameter int FRAC_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleData,
  input  logic [TEMP_W-1:0] limitHigh,
  input  logic [TEMP_W-1:0] limitLow,
  input  logic              intMode,
  input  logic [1:0]        hystCode,
  input  logic              alertPolarity,
  input  logic              cfgReadClr,
  input  logic              arwinClr,
  input  logic              resetCmd,
  output logic              flagHigh,
  output logic              flagLow,
  output logic              alertPin,
  output logic              arDirBit
);

  cmp_t    cmp;
  strobe_t stb;
  logic    alertLatch;
  logic    alertActive;

  thermal_alert_datapath #(
    .TEMP_W    (TEMP_W),
    .FRAC_BITS (FRAC_BITS)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .sampleData (sampleData),
    .limitHigh  (limitHigh),
    .limitLow   (limitLow),
    .hystCode   (hystCode),
    .stb        (stb),
    .cmp        (cmp),
    .flagHigh   (flagHigh),
    .flagLow    (flagLow),
    .alertLatch (alertLatch),
    .dirBit     (arDirBit)
  );

  thermal_alert_ctrl u_ctrl (
    .sampleValid (sampleValid),
    .intMode     (intMode),
    .cfgReadClr  (cfgReadClr),
    .arwinClr    (arwinClr),
    .resetCmd    (resetCmd),
    .cmp         (cmp),
    .stb         (stb)
  );

  assign alertActive = intMode ? alertLatch : (flagHigh | flagLow);
  assign alertPin    = alertPolarity ? alertActive : ~alertActive;

endmodule

// File: rtl/thermal_alert_checker.sv
module thermal_alert_checker #(
  parameter int TEMP_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic [TEMP_W-1:0] sampleData,
  input logic [TEMP_W-1:0] limitHigh,
  input logic [TEMP_W-1:0] limitLow,
  input logic              intMode,
  input logic              cfgReadClr,
  input logic              arwinClr,
  input logic              resetCmd,
  input logic              flagHigh,
  input logic              flagLow,
  input logic              arDirBit,
  input logic              alertActive
);

  // R2
  high_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !resetCmd && ($signed(sampleData) > $signed(limitHigh))) |=> flagHigh);

  // R2
  low_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !resetCmd && ($signed(sampleData) < $signed(limitLow))) |=> flagLow);

  // R10
  dir_over_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !resetCmd && ($signed(sampleData) > $signed(limitHigh))) |=> arDirBit);

  // R10
  dir_under_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !resetCmd && ($signed(sampleData) < $signed(limitLow))
     && !($signed(sampleData) > $signed(limitHigh))) |=> !arDirBit);

  // R11
  wipe_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetCmd |=> (!flagHigh && !flagLow && !arDirBit && !alertActive));

  // R7
  win_clears_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && arwinClr && !sampleValid && !resetCmd) |=> (!intMode || !alertActive));

  // R7
  win_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && arwinClr && !cfgReadClr && !sampleValid && !resetCmd)
    |=> $stable({flagHigh, flagLow}));

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && sampleValid && !resetCmd && ($signed(sampleData) > $signed(limitHigh)))
    |=> (!intMode || alertActive));

  // R12
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !cfgReadClr && !resetCmd) |=> $stable({flagHigh, flagLow, arDirBit}));

endmodule

bind thermal_limit_alert thermal_alert_checker #(.TEMP_W(TEMP_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .sampleData  (sampleData),
  .limitHigh   (limitHigh),
  .limitLow    (limitLow),
  .intMode     (intMode),
  .cfgReadClr  (cfgReadClr),
  .arwinClr    (arwinClr),
  .resetCmd    (resetCmd),
  .flagHigh    (flagHigh),
  .flagLow     (flagLow),
  .arDirBit    (arDirBit),
  .alertActive (alertActive)
);

// File: tb/thermal_limit_alert_tb.sv
module thermal_limit_alert_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TW         = 12;
  localparam int WATCHDOG   = 200000;

  logic          clk = 1'b0;
  logic          rstN;
  logic          sampleValid;
  logic [TW-1:0] sampleData;
  logic [TW-1:0] limitHigh;
  logic [TW-1:0] limitLow;
  logic          intMode;
  logic [1:0]    hystCode;
  logic          alertPolarity;
  logic          cfgReadClr;
  logic          arwinClr;
  logic          resetCmd;
  logic          flagHigh;
  logic          flagLow;
  logic          alertPin;
  logic          arDirBit;

  int checks = 0;
  int errors = 0;
  int mFH = 0, mFL = 0, mLatch = 0, mDir = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  thermal_limit_alert u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .sampleValid   (sampleValid),
    .sampleData    (sampleData),
    .limitHigh     (limitHigh),
    .limitLow      (limitLow),
    .intMode       (intMode),
    .hystCode      (hystCode),
    .alertPolarity (alertPolarity),
    .cfgReadClr    (cfgReadClr),
    .arwinClr      (arwinClr),
    .resetCmd      (resetCmd),
    .flagHigh      (flagHigh),
    .flagLow       (flagLow),
    .alertPin      (alertPin),
    .arDirBit      (arDirBit)
  );

  function automatic int toInt(input logic [TW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int marginOf(input logic [1:0] code);
    int deg;
    deg = (code == 2'd3) ? 4 : int'(code);
    return deg * 16;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkOut(input string req);
    int act;
    act = intMode ? mLatch : ((mFH != 0 || mFL != 0) ? 1 : 0);
    check(req, "flagHigh", int'(flagHigh), mFH);
    check(req, "flagLow", int'(flagLow), mFL);
    check(req, "alertPin", int'(alertPin), alertPolarity ? act : 1 - act);
    check(req, "arDirBit", int'(arDirBit), mDir);
  endtask

  // Expected state from the requirements, in plain integer arithmetic
  task automatic model(input bit sv, input logic [TW-1:0] s, input bit cfg,
                       input bit arw, input bit rc);
    int si, hi, lo, mg;
    bit over, under;
    si = toInt(s); hi = toInt(limitHigh); lo = toInt(limitLow);
    mg = marginOf(hystCode);
    over  = sv && (si > hi);
    under = sv && (si < lo);
    if (rc) begin
      mFH = 0; mFL = 0; mLatch = 0; mDir = 0;
    end else begin
      if (intMode) begin
        if (cfg) begin mFH = 0; mFL = 0; end
        if (cfg || arw) mLatch = 0;
        if (over)  mFH = 1;
        if (under) mFL = 1;
        if (over || under) mLatch = 1;
      end else begin
        mLatch = 0;
        if (sv) begin
          if (over) mFH = 1; else if (si < hi - mg) mFH = 0;
          if (under) mFL = 1; else if (si > lo + mg) mFL = 0;
        end
      end
      if (over) mDir = 1;
      else if (under) mDir = 0;
    end
  endtask

  task automatic cycle(input string req, input bit sv, input logic [TW-1:0] s,
                       input bit cfg, input bit arw, input bit rc);
    sampleValid = sv; sampleData = s; cfgReadClr = cfg; arwinClr = arw; resetCmd = rc;
    @(posedge clk);
    model(sv, s, cfg, arw, rc);
    @(negedge clk);
    sampleValid = 1'b0; cfgReadClr = 1'b0; arwinClr = 1'b0; resetCmd = 1'b0;
    checkOut(req);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; sampleValid = 1'b0; sampleData = '0;
    limitHigh = 12'h7FF; limitLow = 12'h800;
    intMode = 1'b1; hystCode = 2'd1; alertPolarity = 1'b0;
    cfgReadClr = 1'b0; arwinClr = 1'b0; resetCmd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOut("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1");

    // R2: reset-value limits, no code can leave the window
    for (int v = 0; v < 4096; v++) cycle("R2", 1'b1, TW'(v), 1'b0, 1'b0, 1'b0);

    // R5/R6/R10: every code against a +/-25 C window, read-clear between
    limitHigh = 12'h190; limitLow = 12'hE70;
    for (int v = 0; v < 4096; v++) begin
      cycle("R5", 1'b1, TW'(v), 1'b0, 1'b0, 1'b0);
      cycle("R6", 1'b0, '0, 1'b1, 1'b0, 1'b0);
    end

    // R3/R4: comparator sweeps up and down through both limits, all margins
    intMode = 1'b0; limitHigh = 12'h064; limitLow = 12'hFB0;
    for (int h = 0; h < 4; h++) begin
      hystCode = 2'(h);
      for (int s = -200; s <= 220; s++) cycle("R4", 1'b1, TW'(s), 1'b0, 1'b0, 1'b0);
      for (int s = 220; s >= -200; s--) cycle("R3", 1'b1, TW'(s), 1'b0, 1'b0, 1'b0);
    end

    // R6: read and win pulses do nothing in comparator mode
    hystCode = 2'd2;
    cycle("R6", 1'b1, 12'h100, 1'b0, 1'b0, 1'b0);
    cycle("R6", 1'b0, '0, 1'b1, 1'b0, 1'b0);
    cycle("R6", 1'b0, '0, 1'b0, 1'b1, 1'b0);
    cycle("R4", 1'b1, 12'h050, 1'b0, 1'b0, 1'b0);

    // R7: win clears the pin only
    intMode = 1'b1;
    cycle("R11", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    cycle("R7", 1'b1, 12'hF00, 1'b0, 1'b0, 1'b0);
    cycle("R7", 1'b0, '0, 1'b0, 1'b1, 1'b0);
    cycle("R12", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    cycle("R12", 1'b1, 12'h000, 1'b0, 1'b0, 1'b0);

    // R8: new event in the same cycle as the clears
    cycle("R8", 1'b1, 12'h200, 1'b1, 1'b0, 1'b0);
    cycle("R8", 1'b1, 12'h200, 1'b0, 1'b1, 1'b0);
    cycle("R8", 1'b1, 12'h800, 1'b1, 1'b1, 1'b0);

    // R9: polarity flips without a clock edge
    alertPolarity = 1'b1; #1; checkOut("R9");
    cycle("R9", 1'b0, '0, 1'b1, 1'b0, 1'b0);
    alertPolarity = 1'b0; #1; checkOut("R9");

    // R10: direction follows the most recent cause
    cycle("R10", 1'b1, 12'h800, 1'b0, 1'b0, 1'b0);
    cycle("R10", 1'b1, 12'h7FF, 1'b0, 1'b0, 1'b0);
    cycle("R10", 1'b1, 12'h000, 1'b0, 1'b0, 1'b0);

    // R11: reset command beats a coincident out-of-window sample
    cycle("R11", 1'b1, 12'h7FF, 1'b0, 1'b0, 1'b1);
    alertPolarity = 1'b1;
    cycle("R11", 1'b1, 12'h7FF, 1'b0, 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule